// File: doc/BRIEF.md
# Clock-Enable Power-State Controller

This block follows the clock-enable pin of a double-data-rate SDRAM interface. It decides, edge by edge, whether the device is awake, in power-down or in self-refresh. On every rising clock edge it compares the clock-enable level seen at the previous edge with the level seen now, and reads the command pins in the same cycle. A bank tracker supplies a flag that is high when every bank is precharged.

The block drives four outputs. The first is a two-bit power state. The second is an internal clock enable that is low while the device sleeps. The third is a command-blocking signal. The fourth is a one-cycle flag for any breach of the entry rules, the exit rules, the minimum clock-enable width or the lockout that follows self-refresh exit. A device model can use the block to gate its internal clock. A protocol checker can use it to count illegal sequences.

The state machine has four states: AWAKE (code 0), PDOWN (code 1), SELFREF (code 2) and SRX_HOLD (code 3). The transitions are:
- AWAKE to PDOWN on a falling clock enable with an idle or no-op command.
- AWAKE to SELFREF on a falling clock enable with a refresh command.
- PDOWN to AWAKE, and SELFREF to SRX_HOLD, on a rising clock enable with an idle or no-op command.
- SRX_HOLD to AWAKE when the lockout timer expires.

In every other case the state stays where it is.

Top module: `cke_power_ctrl`

## Requirements
- R1: After reset the power state is AWAKE (0), the internal clock enable is 1, and the command-blocking and illegal outputs are 0.
- R2: In AWAKE, when clock enable was high at the previous edge and is low now, all banks are idle, and the command is deselect (cs_n=1) or no-op (cs_n,ras_n,cas_n,we_n = 0,1,1,1), the state becomes PDOWN (1) after that edge.
- R3: Under the same clock-enable fall and idle condition, a refresh command (cs_n,ras_n,cas_n,we_n = 0,0,0,1) moves the state to SELFREF (2).
- R4: A clock-enable fall in AWAKE while the banks are not all idle, or with any command other than deselect, no-op or refresh, raises illegal for one cycle, and the state stays AWAKE.
- R5: While clock enable stays low in PDOWN or SELFREF, the state is held and the command pins have no effect on any output.
- R6: A clock-enable rise in PDOWN or SELFREF with deselect or no-op moves PDOWN to AWAKE and SELFREF to SRX_HOLD (3). A rise with any other command raises illegal and leaves the state unchanged.
- R7: A clock-enable change seen after fewer than MIN_CKE_HOLD (default 2) consecutive edges at the previous level raises illegal for one cycle. The state transition that the change causes still takes place.
- R8: SRX_HOLD lasts for the SR_EXIT_LOCK-1 edges that follow the exit edge (default 20 clocks in total from exit) and then returns to AWAKE. During SRX_HOLD the following raise illegal: a command with clock enable high other than deselect, no-op or column (cs_n,ras_n,cas_n = 0,1,0), and a clock-enable fall.
- R9: The internal clock enable is 0 exactly in PDOWN and SELFREF. The command-blocking output is 1 in every state other than AWAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | High when every bank is precharged |
| pwr_state | output | 2 | Current power state code |
| int_clk_en | output | 1 | Internal clock enable |
| cmd_block | output | 1 | Commands are blocked or restricted |
| illegal | output | 1 | One-cycle protocol violation flag |

## Verification
The width check and the entry or exit rules can both trip on the same edge. An example is a failed exit attempt followed one edge later by a new clock-enable fall, or a fall issued a single edge after a legal wake-up. The bench builds both sequences on purpose. It also toggles clock enable at random against a behavioural reference model. It then expects a single one-cycle illegal pulse, together with the state change that the entry or exit rules alone dictate.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [1:0] {
        PS_AWAKE    = 2'd0,
        PS_PDOWN    = 2'd1,
        PS_SELFREF  = 2'd2,
        PS_SRX_HOLD = 2'd3
    } pwr_state_t;

    typedef enum logic [2:0] {
        CK_DESEL   = 3'd0,
        CK_NOP     = 3'd1,
        CK_REFRESH = 3'd2,
        CK_COLUMN  = 3'd3,
        CK_OTHER   = 3'd4
    } cmd_kind_t;

    function automatic logic is_quiet(input cmd_kind_t k);
        return (k == CK_DESEL) || (k == CK_NOP);
    endfunction

endpackage

// File: rtl/cke_cmd_classify.sv
module cke_cmd_classify
    import cke_pwr_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output cmd_kind_t kind
);

    always_comb begin
        if (cs_n) begin
            kind = CK_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:        kind = CK_NOP;
                3'b001:        kind = CK_REFRESH;
                3'b100, 3'b101: kind = CK_COLUMN;
                default:       kind = CK_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/cke_edge_track.sv
module cke_edge_track #(
    parameter int MIN_CKE_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic cke_fall,
    output logic cke_rise,
    output logic width_err
);

    logic cke_prev_q;
    logic cke_change;

    assign cke_change = (cke != cke_prev_q);
    assign cke_fall   = cke_prev_q & ~cke;
    assign cke_rise   = ~cke_prev_q & cke;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_prev_q <= 1'b1;
        else        cke_prev_q <= cke;
    end

    generate
        if (MIN_CKE_HOLD <= 1) begin : g_no_width
            assign width_err = 1'b0;
        end else begin : g_width
            localparam int RUN_W = $clog2(MIN_CKE_HOLD + 1);
            localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_CKE_HOLD);
            logic [RUN_W-1:0] run_q;

            assign width_err = cke_change && (run_q < RUN_MAX);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    run_q <= RUN_MAX;
                end else if (cke_change) begin
                    run_q <= RUN_W'(1);
                end else if (run_q < RUN_MAX) begin
                    run_q <= run_q + RUN_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
    parameter int SR_EXIT_LOCK = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (SR_EXIT_LOCK > 2) ? $clog2(SR_EXIT_LOCK) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SR_EXIT_LOCK - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
    import cke_pwr_pkg::*;
#(
    parameter int MIN_CKE_HOLD = 2,
    parameter int SR_EXIT_LOCK = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       all_idle,
    output logic [1:0] pwr_state,
    output logic       int_clk_en,
    output logic       cmd_block,
    output logic       illegal
);

    pwr_state_t state_q, state_d;
    cmd_kind_t  kind;
    logic       cke_fall, cke_rise, width_err;
    logic       lock_load, lock_expire;
    logic       rule_err;
    logic       quiet;

    logic       illegal_q, clk_en_q, block_q;

    cke_cmd_classify u_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .kind  (kind)
    );

    cke_edge_track #(.MIN_CKE_HOLD(MIN_CKE_HOLD)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cke_fall  (cke_fall),
        .cke_rise  (cke_rise),
        .width_err (width_err)
    );

    cke_exit_timer #(.SR_EXIT_LOCK(SR_EXIT_LOCK)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (lock_load),
        .run    (state_q == PS_SRX_HOLD),
        .expire (lock_expire)
    );

    assign quiet = is_quiet(kind);

    // Next-state and rule evaluation
    always_comb begin
        state_d  = state_q;
        rule_err = 1'b0;
        unique case (state_q)
            PS_AWAKE: begin
                if (cke_fall) begin
                    if (all_idle && quiet)                   state_d = PS_PDOWN;
                    else if (all_idle && kind == CK_REFRESH) state_d = PS_SELFREF;
                    else                                     rule_err = 1'b1;
                end
            end
            PS_PDOWN: begin
                if (cke_rise) begin
                    if (quiet) state_d  = PS_AWAKE;
                    else       rule_err = 1'b1;
                end
            end
            PS_SELFREF: begin
                if (cke_rise) begin
                    if (quiet) state_d  = PS_SRX_HOLD;
                    else       rule_err = 1'b1;
                end
            end
            PS_SRX_HOLD: begin
                if (cke_fall) rule_err = 1'b1;
                if (cke && !(quiet || kind == CK_COLUMN)) rule_err = 1'b1;
                if (lock_expire) state_d = PS_AWAKE;
            end
            default: state_d = PS_AWAKE;
        endcase
    end

    assign lock_load = (state_q == PS_SELFREF) && (state_d == PS_SRX_HOLD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_AWAKE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            illegal_q <= 1'b0;
            clk_en_q  <= 1'b1;
            block_q   <= 1'b0;
        end else begin
            illegal_q <= rule_err | width_err;
            clk_en_q  <= (state_d == PS_AWAKE) || (state_d == PS_SRX_HOLD);
            block_q   <= (state_d != PS_AWAKE);
        end
    end

    assign pwr_state  = state_q;
    assign int_clk_en = clk_en_q;
    assign cmd_block  = block_q;
    assign illegal    = illegal_q;

endmodule

// File: rtl/cke_power_ctrl_chk.sv
module cke_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       all_idle,
    input logic [1:0] pwr_state,
    input logic       int_clk_en
);

    // R2: power-down is entered only from awake, on a low clock enable with idle banks
    p_pdown_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 && $past(pwr_state) == 2'd0) |-> ($past(all_idle) && !$past(cke)));

    // R3: self-refresh entry also needs idle banks and a low clock enable
    p_sref_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 && $past(pwr_state) != 2'd2) |-> ($past(all_idle) && !$past(cke)));

    // R5: a sleeping state is held while clock enable stays low
    p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == 2'd1 || pwr_state == 2'd2) && !cke) |=> $stable(pwr_state));

    // R6: leaving self-refresh always lands in the exit lockout
    p_sref_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'd2 && pwr_state != 2'd2) |-> pwr_state == 2'd3);

    // R8: the lockout is reached only from self-refresh
    p_hold_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && $past(pwr_state) != 2'd3) |-> $past(pwr_state) == 2'd2);

    // R9: internal clock runs only while awake or in the lockout
    p_clk_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_clk_en == (pwr_state == 2'd0 || pwr_state == 2'd3));

endmodule

bind cke_power_ctrl cke_power_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .all_idle   (all_idle),
    .pwr_state  (pwr_state),
    .int_clk_en (int_clk_en)
);

// File: tb/test_cke_power_ctrl.sv
`timescale 1ns/1ps
module test_cke_power_ctrl;

    localparam int MIN_HOLD = 2;
    localparam int LOCK     = 20;

    // command codes used by the bench
    localparam int C_DESEL = 0, C_NOP = 1, C_REF = 2, C_READ = 3,
                   C_ACT = 4, C_PRE = 5, C_MRS = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic all_idle = 1'b1;
    logic [1:0] pwr_state;
    logic int_clk_en, cmd_block, illegal;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int m_state, m_prev, m_run, m_elapsed, m_ill, m_cen, m_blk;

    always #4 clk = ~clk;

    cke_power_ctrl #(.MIN_CKE_HOLD(MIN_HOLD), .SR_EXIT_LOCK(LOCK)) i_cke_power_ctrl (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .all_idle(all_idle),
        .pwr_state(pwr_state), .int_clk_en(int_clk_en),
        .cmd_block(cmd_block), .illegal(illegal)
    );

    task automatic set_cmd(input int c);
        case (c)
            C_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            C_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            C_READ:  {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        endcase
    endtask

    task automatic model_reset();
        m_state = 0; m_prev = 1; m_run = MIN_HOLD; m_elapsed = 0;
        m_ill = 0; m_cen = 1; m_blk = 0;
    endtask

    task automatic model_edge();
        int ns, bad, k, quiet_c, refr, col;
        ns = m_state; bad = 0; k = int'(cke);
        quiet_c = (cs_n || (ras_n && cas_n && we_n)) ? 1 : 0;
        refr = (!cs_n && !ras_n && !cas_n && we_n) ? 1 : 0;
        col  = (!cs_n && ras_n && !cas_n) ? 1 : 0;
        if (k != m_prev && m_run < MIN_HOLD) bad = 1;
        if (m_state == 0) begin
            if (m_prev == 1 && k == 0) begin
                if (all_idle && quiet_c) ns = 1;
                else if (all_idle && refr) ns = 2;
                else bad = 1;
            end
        end else if (m_state == 1 || m_state == 2) begin
            if (m_prev == 0 && k == 1) begin
                if (quiet_c) begin
                    ns = (m_state == 1) ? 0 : 3;
                    m_elapsed = 0;
                end else bad = 1;
            end
        end else begin
            m_elapsed++;
            if (m_prev == 1 && k == 0) bad = 1;
            if (k == 1 && !(quiet_c || col)) bad = 1;
            if (m_elapsed == LOCK - 1) ns = 0;
        end
        if (k != m_prev) m_run = 1;
        else if (m_run < MIN_HOLD) m_run++;
        m_prev = k; m_state = ns; m_ill = bad;
        m_cen = (ns == 0 || ns == 3) ? 1 : 0;
        m_blk = (ns != 0) ? 1 : 0;
    endtask

    task automatic compare(input string tag);
        logic [4:0] act, exp;
        act = {pwr_state, int_clk_en, cmd_block, illegal};
        exp = {2'(m_state), 1'(m_cen), 1'(m_blk), 1'(m_ill)};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {state,clk_en,block,illegal} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    // drive at the falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input logic k, input int c, input logic idle, input string tag);
        cke = k; set_cmd(c); all_idle = idle;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_fail++; n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        int lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        repeat (3) step(1, C_NOP, 1, "R1 idle awake");

        // power-down entry, hold, bad exit, clean exit
        step(0, C_NOP, 1, "R2 pdown entry");
        step(0, C_ACT, 1, "R5 hold act");
        step(0, C_MRS, 0, "R5 hold mrs");
        step(0, C_REF, 1, "R5 hold ref");
        step(1, C_ACT, 1, "R6 bad exit");
        step(0, C_NOP, 1, "R7 narrow high in pdown");
        step(0, C_NOP, 1, "R5 hold");
        step(1, C_DESEL, 1, "R6 pdown exit");
        step(0, C_NOP, 1, "R7 fall one edge after rise");
        step(0, C_NOP, 1, "R5 hold");
        step(1, C_NOP, 1, "R6 exit");
        step(1, C_NOP, 1, "R9 awake");

        // entry refusals
        step(0, C_NOP, 0, "R4 not idle");
        step(0, C_NOP, 1, "R4 low in awake");
        step(1, C_NOP, 1, "R4 rise in awake");
        step(1, C_NOP, 1, "R4 settle");
        step(0, C_ACT, 1, "R4 wrong cmd");
        step(1, C_NOP, 1, "R4 rise");
        step(1, C_NOP, 1, "R4 settle");

        // self-refresh and lockout
        step(0, C_REF, 1, "R3 sref entry");
        repeat (4) step(0, C_READ, 0, "R5 hold sref");
        step(1, C_PRE, 1, "R6 bad sref exit");
        step(1, C_NOP, 1, "R6 stuck");
        step(0, C_NOP, 1, "R6 low again");
        step(0, C_NOP, 1, "R6 low");
        step(1, C_NOP, 1, "R6 sref exit");
        step(1, C_READ, 1, "R8 column ok");
        step(1, C_ACT, 1, "R8 act in lockout");
        for (int i = 0; i < LOCK; i++) step(1, C_NOP, 1, "R8 lockout run");
        step(0, C_REF, 1, "R3 sref again");
        step(0, C_NOP, 1, "R5 hold");
        step(1, C_DESEL, 1, "R6 exit again");
        step(1, C_NOP, 1, "R8 lock");
        step(0, C_NOP, 1, "R8 fall in lockout");
        step(0, C_NOP, 1, "R8 low in lockout");
        for (int i = 0; i < LOCK; i++) step(1, C_MRS, 1, "R8 mrs in lockout");

        // pseudo-random mix
        lfsr = 32'h1ace;
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
            step(((lfsr & 3) == 0) ? ~cke : cke, (lfsr >> 4) % 7,
                 ((lfsr >> 8) & 7) != 0, "R9 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule